// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Unit

This block watches every CPU bus cycle on two comparison channels, A and B. It raises a break request when a cycle meets the conditions that software has programmed. Each channel checks the following properties of the cycle:

- the address, under a bit mask;
- an 8-bit address-space identifier;
- the cycle kind (instruction fetch or data access);
- the direction;
- the access size.

Channel B can also compare the cycle's data under its own mask.

The two channels can act independently, so that either one breaks on its own. In chained mode, channel A only arms channel B. Channel B then breaks on its first qualifying match after A has hit. Channel B can also hold its break back until its Nth qualifying match. Breaks on fetch cycles are meant to be taken before the fetched instruction runs, so the break request is combinational. It pulses in the same cycle as the matching bus descriptor. Each channel has a sticky match flag, which software clears through the register port.

Top module: `bus_brk_unit`

## Requirements
- R1: A channel matches only when `(cyc_addr ^ addr_reg) & ~mask_reg` is zero; a mask bit of 1 excludes that address bit from the compare.
- R2: A channel matches only when `cyc_asid` equals the identifier in control bits [7:0].
- R3: Control bits [9:8] select kind (0 any, 1 fetch, 2 data, 3 never). Bits [11:10] select direction (0 any, 1 read, 2 write, 3 never). Bits [13:12] select size (0 any, 1 byte, 2 word, 3 longword), where `cyc_size` is encoded 0 byte, 1 word, 2 longword. A fetch cycle never satisfies direction 2, even with `cyc_write` high.
- R4: When channel B control bit 14 is set, B also requires `(cyc_data ^ data_reg) & ~dmask_reg` to be zero.
- R5: With mode bit 0 clear, a match on either enabled channel (control bit 15) raises `brk_req`.
- R6: With mode bit 0 set, a channel A match raises no break and arms B. A B match raises a break only if A matched in an earlier cycle.
- R7: The armed state clears when a chained break is taken and when the mode register (offset 8) is written.
- R8: With mode bit 1 set and count N (offset 9), the first N−1 qualifying B matches raise no break and the Nth does. The count then reloads from N.
- R9: A count of 0 or 1 breaks on the first qualifying B match.
- R10: `match_a`/`match_b` set one cycle after their channel matches and stay set until a write to offset 10 with bit 0/bit 1 set. A new match in the same cycle keeps the flag set.
- R11: `brk_req` is high only while `cyc_valid` is high, in the same cycle as the matching descriptor.

Register offsets: 0 A address, 1 A mask, 2 A control, 3 B address, 4 B mask, 5 B control, 6 B data, 7 B data mask, 8 mode, 9 count, 10 flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | Bus descriptor valid this cycle |
| cyc_addr | input | 32 | Cycle address |
| cyc_asid | input | 8 | Current address-space identifier |
| cyc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cyc_write | input | 1 | 1 = write, 0 = read |
| cyc_size | input | 2 | 0 byte, 1 word, 2 longword |
| cyc_data | input | 32 | Cycle data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| brk_req | output | 1 | Break request pulse |
| match_a | output | 1 | Sticky channel A match flag |
| match_b | output | 1 | Sticky channel B match flag |

## Verification
The bench targets the following corner cases:

- A fetch cycle presented with the write line high against a write-only channel. A design that trusted `cyc_write` alone would break there.
- In chained mode, a B hit arriving before any A hit. A design without arming would break too early.
- A second B hit after a chained break, and a B hit after the mode was rewritten. A design that never dropped the armed state would break on both.
- A count of five, run twice over. An off-by-one counter would break on the fourth or sixth match, or would miss the reload.
- Counts of zero and one, where a naive down-counter could wrap and never break.

// File: rtl/bus_brk_unit.sv
module bus_brk_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  input  logic [IW-1:0] cyc_asid,
  input  logic          cyc_fetch,
  input  logic          cyc_write,
  input  logic [1:0]    cyc_size,
  input  logic [DW-1:0] cyc_data,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic          brk_req,
  output logic          match_a,
  output logic          match_b
);
  localparam logic [3:0] OFS_A_ADDR = 4'd0;
  localparam logic [3:0] OFS_A_MASK = 4'd1;
  localparam logic [3:0] OFS_A_CTL  = 4'd2;
  localparam logic [3:0] OFS_B_ADDR = 4'd3;
  localparam logic [3:0] OFS_B_MASK = 4'd4;
  localparam logic [3:0] OFS_B_CTL  = 4'd5;
  localparam logic [3:0] OFS_B_DATA = 4'd6;
  localparam logic [3:0] OFS_B_DMSK = 4'd7;
  localparam logic [3:0] OFS_MODE   = 4'd8;
  localparam logic [3:0] OFS_COUNT  = 4'd9;
  localparam logic [3:0] OFS_CLEAR  = 4'd10;

  logic [AW-1:0] a_addr, a_mask, b_addr, b_mask;
  logic [DW-1:0] b_data, b_dmsk;
  logic [15:0]   a_ctl, b_ctl;
  logic [1:0]    mode;
  logic [CW-1:0] cnt_set, cnt_left;
  logic          armed;

  function automatic logic qual_ok(input logic [15:0] ctl, input logic [IW-1:0] asid,
                                   input logic fetch, input logic wr, input logic [1:0] sz);
    logic k_ok, d_ok, s_ok;
    k_ok = (ctl[9:8] == 2'd0) || (ctl[9:8] == 2'd1 && fetch) || (ctl[9:8] == 2'd2 && !fetch);
    d_ok = (ctl[11:10] == 2'd0) || (ctl[11:10] == 2'd1 && !wr) ||
           (ctl[11:10] == 2'd2 && wr && !fetch);
    s_ok = (ctl[13:12] == 2'd0) || (ctl[13:12] == sz + 2'd1);
    return ctl[15] && k_ok && d_ok && s_ok && (ctl[IW-1:0] == asid);
  endfunction

  wire wr_hit   = reg_we;
  wire wr_mode  = wr_hit && reg_addr == OFS_MODE;
  wire wr_count = wr_hit && reg_addr == OFS_COUNT;
  wire wr_clear = wr_hit && reg_addr == OFS_CLEAR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr <= '0; a_mask <= '0; a_ctl <= '0;
      b_addr <= '0; b_mask <= '0; b_ctl <= '0;
      b_data <= '0; b_dmsk <= '0;
      mode <= '0; cnt_set <= '0;
    end else if (wr_hit) begin
      case (reg_addr)
        OFS_A_ADDR: a_addr  <= reg_wdata[AW-1:0];
        OFS_A_MASK: a_mask  <= reg_wdata[AW-1:0];
        OFS_A_CTL:  a_ctl   <= reg_wdata[15:0];
        OFS_B_ADDR: b_addr  <= reg_wdata[AW-1:0];
        OFS_B_MASK: b_mask  <= reg_wdata[AW-1:0];
        OFS_B_CTL:  b_ctl   <= reg_wdata[15:0];
        OFS_B_DATA: b_data  <= reg_wdata[DW-1:0];
        OFS_B_DMSK: b_dmsk  <= reg_wdata[DW-1:0];
        OFS_MODE:   mode    <= reg_wdata[1:0];
        OFS_COUNT:  cnt_set <= reg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  wire addr_ok_a = ((cyc_addr ^ a_addr) & ~a_mask) == '0;
  wire addr_ok_b = ((cyc_addr ^ b_addr) & ~b_mask) == '0;
  wire data_ok_b = !b_ctl[14] || (((cyc_data ^ b_data) & ~b_dmsk) == '0);

  wire hit_a = cyc_valid && addr_ok_a &&
               qual_ok(a_ctl, cyc_asid, cyc_fetch, cyc_write, cyc_size);
  wire hit_b = cyc_valid && addr_ok_b && data_ok_b &&
               qual_ok(b_ctl, cyc_asid, cyc_fetch, cyc_write, cyc_size);

  wire seq_mode = mode[0];
  wire cnt_en   = mode[1];
  wire b_qual   = hit_b && (!seq_mode || armed);
  wire b_last   = !cnt_en || (cnt_left <= CW'(1));
  wire brk_b    = b_qual && b_last;
  wire brk_a    = hit_a && !seq_mode;

  assign brk_req = brk_a || brk_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     armed <= 1'b0;
    else if (wr_mode)               armed <= 1'b0;
    else if (seq_mode && brk_b)     armed <= 1'b0;
    else if (seq_mode && hit_a)     armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_left <= '0;
    else if (wr_count)              cnt_left <= reg_wdata[CW-1:0];
    else if (wr_mode)               cnt_left <= cnt_set;
    else if (cnt_en && b_qual)      cnt_left <= b_last ? cnt_set : cnt_left - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_a <= 1'b0;
      match_b <= 1'b0;
    end else begin
      match_a <= hit_a || (match_a && !(wr_clear && reg_wdata[0]));
      match_b <= hit_b || (match_b && !(wr_clear && reg_wdata[1]));
    end
  end

  p_brk_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> cyc_valid);

  p_sticky_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && !(wr_clear && reg_wdata[0])) |=> match_a);

  p_sticky_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (match_b && !(wr_clear && reg_wdata[1])) |=> match_b);

  p_seq_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && brk_req && !reg_we) |=> !armed);

  p_mode_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> !armed);

  p_cnt_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && brk_b && !reg_we) |=> cnt_left == cnt_set);

  p_seq_a_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && brk_req) |-> hit_b);
endmodule

// File: tb/bus_brk_unit_tb.sv
`timescale 1ns/1ps
module bus_brk_unit_tb;
  logic clk = 0, rst_n = 0;
  logic cyc_valid = 0, cyc_fetch = 0, cyc_write = 0;
  logic [31:0] cyc_addr = 0, cyc_data = 0, reg_wdata = 0;
  logic [7:0] cyc_asid = 0;
  logic [1:0] cyc_size = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic brk_req, match_a, match_b;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  bus_brk_unit u_dut (.clk, .rst_n, .cyc_valid, .cyc_addr, .cyc_asid, .cyc_fetch,
    .cyc_write, .cyc_size, .cyc_data, .reg_we, .reg_addr, .reg_wdata,
    .brk_req, .match_a, .match_b);

  function automatic logic [31:0] ctl(bit en, bit dcmp, logic [1:0] sz, logic [1:0] dir,
                                      logic [1:0] kind, logic [7:0] asid);
    return {16'b0, en, dcmp, sz, dir, kind, asid};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1 reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 0;
  endtask

  task automatic cyc(logic [31:0] a, logic [7:0] id, bit f, bit w, logic [1:0] s,
                     logic [31:0] d, bit exp, string tag);
    @(posedge clk); #1
    cyc_valid = 1; cyc_addr = a; cyc_asid = id; cyc_fetch = f; cyc_write = w;
    cyc_size = s; cyc_data = d;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1 cyc_valid = 0;
  endtask

  always @(negedge clk) if (cyc_valid) begin
    if (exp_q.size() == 0) check("monitor: unexpected cycle", 1, 0);
    else begin
      bit e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(t, brk_req, e);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10 reset match_a", match_a, 0);
    check("R10 reset match_b", match_b, 0);
    check("R11 reset brk", brk_req, 0);
    rst_n = 1;

    // Channel A: fetch, read, longword, asid 0x80
    wr(0, 32'h500); wr(1, 0); wr(2, ctl(1, 0, 2'd3, 2'd1, 2'd1, 8'h80));
    cyc(32'h500, 8'h80, 1, 0, 2, 0, 1, "R5 R1 A exact hit");
    cyc(32'h504, 8'h80, 1, 0, 2, 0, 0, "R1 A addr miss");
    cyc(32'h500, 8'h81, 1, 0, 2, 0, 0, "R2 A asid miss");
    cyc(32'h500, 8'h80, 1, 0, 1, 0, 0, "R3 A size miss");
    cyc(32'h500, 8'h80, 0, 0, 2, 0, 0, "R3 A kind miss");
    check("R10 match_a set", match_a, 1);
    check("R10 match_b clear", match_b, 0);
    wr(1, 32'hF);
    cyc(32'h50C, 8'h80, 1, 0, 2, 0, 1, "R1 A masked hit");
    // R11: matching fields without valid
    @(posedge clk); #1 cyc_addr = 32'h500; cyc_asid = 8'h80; cyc_fetch = 1;
    cyc_write = 0; cyc_size = 2;
    @(negedge clk) check("R11 no brk without valid", brk_req, 0);
    wr(10, 1);
    check("R10 match_a cleared", match_a, 0);
    // write qualifier
    wr(2, ctl(1, 0, 2'd0, 2'd2, 2'd0, 8'h80));
    cyc(32'h500, 8'h80, 1, 1, 2, 0, 0, "R3 fetch never a write");
    cyc(32'h500, 8'h80, 0, 1, 2, 0, 1, "R3 data write hit");
    wr(2, 0);
    wr(10, 3);

    // Channel B with data compare
    wr(3, 32'h1000); wr(4, 0); wr(6, 32'h1234_5678); wr(7, 32'hFF);
    wr(5, ctl(1, 1, 2'd0, 2'd0, 2'd2, 8'h70));
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5600, 1, "R4 B data masked hit");
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1235_5678, 0, "R4 B data miss");
    check("R10 match_b set", match_b, 1);

    // Sequence mode: A on 0x500 fetch any, B as above
    wr(2, ctl(1, 0, 2'd0, 2'd0, 2'd1, 8'h70));
    wr(8, 1);
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 0, "R6 B before A");
    cyc(32'h500, 8'h70, 1, 0, 2, 0, 0, "R6 A arms silently");
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 1, "R6 B after A");
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 0, "R7 disarmed after break");
    cyc(32'h500, 8'h70, 1, 0, 2, 0, 0, "R6 A re-arm");
    wr(8, 1);
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 0, "R7 mode write disarms");

    // Count mode, independent, A off
    wr(2, 0);
    wr(9, 5); wr(8, 2);
    for (int r = 0; r < 2; r++)
      for (int i = 1; i <= 5; i++)
        cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, i == 5, "R8 count five");
    wr(9, 1);
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 1, "R9 count one");
    wr(9, 0);
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 1, "R9 count zero");
    cyc(32'h1000, 8'h70, 0, 0, 2, 32'h1234_5678, 1, "R9 count zero again");

    repeat (2) @(posedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule